// File: doc/BRIEF.md
# Padded Multiplex Frame Assembler

This block turns a continuous fundamental multiplex bit stream into the bearer stream. After every fifteen data bits it places one padding bit. Across a frame, the padding bits carry four subframe alignment words and a housekeeping field. The alignment words are not sent as one contiguous header. Each word is spread one bit per padding slot, and the slots sit sixteen bit times apart.

The bearer timing supplies a bit-enable, and each enabled cycle produces one output bit. The upstream source sees `in_ready`. It is low during padding slots, and a data bit is taken only when `in_ready` and `bit_en` are both high. Housekeeping bits come from a parallel load port. A justification request can shorten or lengthen one frame by a single padding bit. Two markers are provided: one for the first bit of each frame and one for the first bit of each ten-bit data envelope.

Top module: `pad_frame_assembler`

## Requirements
- R1: Every 16-bit group holds 15 data bits (slots 0..14) followed by one padding bit (slot 15). `in_ready` is high exactly on data slots, and a data slot outputs the `din` value sampled with `bit_en`.
- R2: A nominal frame is 160 groups (2560 bits). `frame_start` is high together with the first output bit of every frame.
- R3: A subframe is 40 groups. Its padding bits 0..13 carry 11111001101010, leftmost bit first.
- R4: Padding bits 14 and 15 of a subframe carry its 2-bit index (0..3), MSB first.
- R5: Padding bits 16..39 of subframe k carry bits [95-24k : 72-24k] of the frame's 96-bit housekeeping word, MSB first.
- R6: `hk_load` captures `hk_in` into a staging register. The staging value becomes the frame's housekeeping word on the first bit of a frame, so a load during a frame affects only the next frame.
- R7: `just_req` is sampled only with the first bit of a frame, using this encoding:
  - 00 or 11: no change.
  - 01: the frame's last padding bit is dropped, giving 2559 bits.
  - 10: one extra padding bit of value 0 is appended after the last padding bit, giving 2561 bits, with `in_ready` low during it.
- R8: `env_strobe` is high with every tenth data bit, counting from the first data bit of the frame (data bits 0, 10, 20, ...).
- R9: While `bit_en` is low, `dout` holds, both markers are low and the frame position does not move.
- R10: A synchronous active-low reset clears the outputs, returns the position to the first bit of a frame, and clears any justification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Bearer bit timing; one output bit per high cycle |
| din | input | 1 | Fundamental multiplex data bit |
| in_ready | output | 1 | High when the current slot takes a data bit |
| just_req | input | 2 | Justification request for the frame being started |
| hk_load | input | 1 | Load strobe for the housekeeping staging register |
| hk_in | input | 96 | Housekeeping word for a later frame |
| dout | output | 1 | Bearer output bit, updated the cycle after an enabled edge |
| frame_start | output | 1 | High with the first bit of a frame |
| env_strobe | output | 1 | High with the first bit of each ten-bit envelope |

## Verification
A slot counter that is off by one shows at the ports as a misplaced `in_ready` low within sixteen bits. A wrong subframe or group count corrupts an alignment or identifier bit within one subframe, which is at most 640 bits. A justification error, or a wrong frame-length decision, shifts the next `frame_start` by one bit and is caught on the first bit of the following frame. A housekeeping transfer taken at the wrong time shows as wrong field bits in the first subframe after the load.

// File: rtl/pfa_pkg.sv
// Package: shared constants and the justification type for the frame assembler.
// Assumes: alignment word length and value are fixed by the framing method.
package pfa_pkg;
    localparam int                 SYNC_LEN  = 14;
    localparam logic [SYNC_LEN-1:0] SYNC_WORD = 14'b11111001101010;

    typedef enum logic [1:0] {
        JUST_NONE  = 2'd0,
        JUST_DROP  = 2'd1,
        JUST_STUFF = 2'd2
    } just_e;

    // Map the request code onto a mode; the spare code means no change.
    function automatic just_e decode_just(input logic [1:0] code);
        case (code)
            2'b01:   return JUST_DROP;
            2'b10:   return JUST_STUFF;
            default: return JUST_NONE;
        endcase
    endfunction
endpackage

// File: rtl/pfa_slot_timer.sv
// Slot timer: tracks the bit slot within a group, the group within a subframe,
// the subframe within a frame, and the extra stuffing slot.
// Assumes: moves one slot per cycle with bit_en high; the justification mode is
// latched on the first slot of a frame and holds for that frame.
module pfa_slot_timer
    import pfa_pkg::*;
#(
    parameter int DATA_BITS     = 15,
    parameter int GROUPS_PER_SF = 40,
    parameter int SUBFRAMES     = 4,
    parameter int SLOT_W        = $clog2(DATA_BITS + 1),
    parameter int PIDX_W        = $clog2(GROUPS_PER_SF),
    parameter int SUB_W         = $clog2(SUBFRAMES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [1:0]        just_req,
    output logic              is_pad,
    output logic              is_extra,
    output logic              frame_first,
    output logic [SUB_W-1:0]  sub_idx,
    output logic [PIDX_W-1:0] pad_idx
);
    localparam logic [SLOT_W-1:0] PAD_SLOT  = SLOT_W'(DATA_BITS);
    localparam logic [SLOT_W-1:0] LAST_DATA = SLOT_W'(DATA_BITS - 1);
    localparam logic [PIDX_W-1:0] LAST_GRP  = PIDX_W'(GROUPS_PER_SF - 1);
    localparam logic [SUB_W-1:0]  LAST_SUB  = SUB_W'(SUBFRAMES - 1);

    logic [SLOT_W-1:0] slot;
    logic              extra;
    just_e             mode;
    logic              last_group;

    // Decode the current slot kind.
    always_comb begin
        last_group  = (sub_idx == LAST_SUB) && (pad_idx == LAST_GRP);
        is_pad      = (slot == PAD_SLOT) || extra;
        is_extra    = extra;
        frame_first = (slot == '0) && (pad_idx == '0) && (sub_idx == '0) && !extra;
    end

    // Advance the position on each enabled bit, applying justification at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot    <= '0;
            pad_idx <= '0;
            sub_idx <= '0;
            extra   <= 1'b0;
            mode    <= JUST_NONE;
        end else if (bit_en) begin
            if (frame_first)
                mode <= decode_just(just_req);
            if (extra) begin
                extra <= 1'b0;
            end else if (slot == LAST_DATA && last_group && mode == JUST_DROP) begin
                slot    <= '0;
                pad_idx <= '0;
                sub_idx <= '0;
            end else if (slot == PAD_SLOT) begin
                slot <= '0;
                if (last_group) begin
                    pad_idx <= '0;
                    sub_idx <= '0;
                    extra   <= (mode == JUST_STUFF);
                end else if (pad_idx == LAST_GRP) begin
                    pad_idx <= '0;
                    sub_idx <= sub_idx + 1'b1;
                end else begin
                    pad_idx <= pad_idx + 1'b1;
                end
            end else begin
                slot <= slot + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pfa_pad_source.sv
// Padding source: selects the value of the current padding bit from the
// alignment word, the subframe index or the housekeeping word.
// Assumes: housekeeping bits are consumed in frame order, MSB first; the
// staging value is transferred on the first slot of each frame.
module pfa_pad_source
    import pfa_pkg::*;
#(
    parameter int HK_BITS = 96,
    parameter int PIDX_W  = 6,
    parameter int SUB_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_en,
    input  logic               frame_first,
    input  logic               is_pad,
    input  logic               is_extra,
    input  logic [SUB_W-1:0]   sub_idx,
    input  logic [PIDX_W-1:0]  pad_idx,
    input  logic               hk_load,
    input  logic [HK_BITS-1:0] hk_in,
    output logic               pad_bit
);
    localparam int ALIGN_W = SYNC_LEN + SUB_W;
    localparam int AW      = $clog2(ALIGN_W);

    logic [HK_BITS-1:0] hk_stage;
    logic [HK_BITS-1:0] hk_work;
    logic [ALIGN_W-1:0] align_word;
    logic [AW-1:0]      aidx;
    logic               in_align;

    // Staging register for the next frame's housekeeping word.
    always_ff @(posedge clk) begin
        if (!rst_n)       hk_stage <= '0;
        else if (hk_load) hk_stage <= hk_in;
    end

    // Working copy: loaded at frame start, shifted as housekeeping slots go out.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hk_work <= '0;
        else if (bit_en && frame_first)
            hk_work <= hk_stage;
        else if (bit_en && is_pad && !is_extra && !in_align)
            hk_work <= {hk_work[HK_BITS-2:0], 1'b0};
    end

    // Select the padding bit for the current position.
    always_comb begin
        align_word = {SYNC_WORD, sub_idx};
        aidx       = AW'(pad_idx);
        in_align   = pad_idx < PIDX_W'(ALIGN_W);
        if (is_extra)      pad_bit = 1'b0;
        else if (in_align) pad_bit = align_word[AW'(ALIGN_W - 1) - aidx];
        else               pad_bit = hk_work[HK_BITS-1];
    end
endmodule

// File: rtl/pad_frame_assembler.sv
// Top: merges data and padding bits into the bearer stream, and generates the
// frame and envelope markers.
// Assumes: one output bit per bit_en; the source offers a valid din whenever
// in_ready is high.
module pad_frame_assembler
    import pfa_pkg::*;
#(
    parameter int DATA_BITS     = 15,
    parameter int GROUPS_PER_SF = 40,
    parameter int SUBFRAMES     = 4,
    parameter int ENV_BITS      = 10,
    parameter int HK_BITS       = (GROUPS_PER_SF - SYNC_LEN - $clog2(SUBFRAMES)) * SUBFRAMES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_en,
    input  logic               din,
    output logic               in_ready,
    input  logic [1:0]         just_req,
    input  logic               hk_load,
    input  logic [HK_BITS-1:0] hk_in,
    output logic               dout,
    output logic               frame_start,
    output logic               env_strobe
);
    localparam int PIDX_W = $clog2(GROUPS_PER_SF);
    localparam int SUB_W  = $clog2(SUBFRAMES);
    localparam int ENV_W  = $clog2(ENV_BITS);
    localparam logic [ENV_W-1:0] ENV_LAST = ENV_W'(ENV_BITS - 1);

    logic              is_pad, is_extra, frame_first, pad_bit;
    logic [SUB_W-1:0]  sub_idx;
    logic [PIDX_W-1:0] pad_idx;
    logic [ENV_W-1:0]  env_cnt;

    pfa_slot_timer #(
        .DATA_BITS(DATA_BITS), .GROUPS_PER_SF(GROUPS_PER_SF), .SUBFRAMES(SUBFRAMES)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .just_req(just_req),
        .is_pad(is_pad), .is_extra(is_extra), .frame_first(frame_first),
        .sub_idx(sub_idx), .pad_idx(pad_idx)
    );

    pfa_pad_source #(
        .HK_BITS(HK_BITS), .PIDX_W(PIDX_W), .SUB_W(SUB_W)
    ) u_pad (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_first(frame_first),
        .is_pad(is_pad), .is_extra(is_extra), .sub_idx(sub_idx), .pad_idx(pad_idx),
        .hk_load(hk_load), .hk_in(hk_in), .pad_bit(pad_bit)
    );

    // Data is taken only on data slots.
    assign in_ready = !is_pad;

    // Count data bits modulo the envelope size, restarting at each frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            env_cnt <= '0;
        else if (bit_en && !is_pad)
            env_cnt <= (frame_first || env_cnt == ENV_LAST) ?
                       ((frame_first && ENV_BITS > 1) ? ENV_W'(1) : '0) : env_cnt + 1'b1;
    end

    // Register the output bit and the markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout        <= 1'b0;
            frame_start <= 1'b0;
            env_strobe  <= 1'b0;
        end else begin
            frame_start <= bit_en && frame_first;
            env_strobe  <= bit_en && !is_pad && (frame_first || env_cnt == '0);
            if (bit_en)
                dout <= is_pad ? pad_bit : din;
        end
    end
endmodule

// File: rtl/pfa_checker.sv
// Checker: temporal properties on the assembler's ports.
// Assumes: bound to every pad_frame_assembler instance.
module pfa_checker (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic in_ready,
    input logic dout,
    input logic frame_start,
    input logic env_strobe
);
    logic pv;

    // Remember whether the previous cycle was out of reset.
    always_ff @(posedge clk) pv <= rst_n;

    assert_frame_on_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pv && frame_start |-> $past(bit_en) && $past(in_ready));

    assert_env_on_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pv && env_strobe |-> $past(in_ready));

    assert_frame_opens_env_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> env_strobe);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pv && !$past(bit_en) |-> $stable(dout) && !frame_start && !env_strobe);

    assert_reset_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pv |-> !dout && !frame_start && !env_strobe);
endmodule

bind pad_frame_assembler pfa_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_ready(in_ready),
    .dout(dout), .frame_start(frame_start), .env_strobe(env_strobe)
);

// File: tb/tb_pad_frame_assembler.sv
module tb_pad_frame_assembler;
    localparam int CLK_P = 10;
    localparam logic [13:0] SYNC = 14'b11111001101010;

    typedef struct packed {
        logic [1:0]  mode;
        logic        gap;
        logic        load;
        logic        mid;
        logic [11:0] exp_len;
        logic [95:0] hk;
        logic [95:0] hk_mid;
    } vec_t;

    localparam vec_t TABLE [5] = '{
        '{2'b00, 1'b0, 1'b1, 1'b0, 12'd2560, 96'hF0E1_D2C3_B4A5_9687_7869_5A4B, 96'h0},
        '{2'b01, 1'b1, 1'b1, 1'b0, 12'd2559, 96'h1234_5678_9ABC_DEF0_0FED_CBA9, 96'h0},
        '{2'b10, 1'b0, 1'b1, 1'b0, 12'd2561, 96'hAAAA_5555_FFFF_0000_C3C3_3C3C, 96'h0},
        '{2'b11, 1'b0, 1'b1, 1'b1, 12'd2560, 96'h8000_0000_0000_0000_0000_0001,
                                             96'h6B1D_49E2_7F30_A5C8_1E97_D402},
        '{2'b10, 1'b1, 1'b0, 1'b0, 12'd2561, 96'h6B1D_49E2_7F30_A5C8_1E97_D402, 96'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        din = 1'b0;
    logic [1:0]  just_req = 2'b00;
    logic        hk_load = 1'b0;
    logic [95:0] hk_in = '0;
    logic        in_ready, dout, frame_start, env_strobe;
    logic [15:0] lf = 16'hACE1;
    int          n_run = 0;
    int          n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    pad_frame_assembler dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .din(din), .in_ready(in_ready),
        .just_req(just_req), .hk_load(hk_load), .hk_in(hk_in), .dout(dout),
        .frame_start(frame_start), .env_strobe(env_strobe)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one frame described by a table entry and compare every output bit.
    task automatic run_frame(input vec_t v);
        int e_dat = 0, e_rdy = 0, e_fs = 0, e_sync = 0, e_id = 0;
        int e_hk = 0, e_ext = 0, e_env = 0, e_gap = 0, dc = 0;
        if (v.load) begin
            bit_en = 1'b0; hk_in = v.hk; hk_load = 1'b1;
            @(posedge clk); @(negedge clk);
            hk_load = 1'b0;
        end
        for (int k = 0; k < int'(v.exp_len); k++) begin
            int  g = k / 16, s = k % 16, sub = g / 40, p = g % 40, cat;
            bit  pad, val, env_exp, prev;
            pad = (k >= 2560) || (s == 15);
            cat = (k >= 2560) ? 4 : (s < 15) ? 0 : (p < 14) ? 1 : (p < 16) ? 2 : 3;
            case (cat)
                1: val = SYNC[13 - p];
                2: val = (p == 14) ? sub[1] : sub[0];
                3: val = v.hk[95 - (sub * 24 + p - 16)];
                default: val = 1'b0;
            endcase
            env_exp = !pad && (dc % 10 == 0);
            if (!pad) begin
                lf  = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                val = lf[0];
                dc++;
            end
            din      = pad ? ~lf[3] : lf[0];
            bit_en   = 1'b1;
            just_req = (k == 0) ? v.mode : ((v.mode == 2'b01) ? 2'b10 : 2'b01);
            hk_load  = v.mid && (k == 1000);
            if (v.mid && k == 1000) hk_in = v.hk_mid;
            #1;
            if (in_ready !== !pad) e_rdy++;
            @(posedge clk); @(negedge clk);
            hk_load = 1'b0;
            if (dout !== val) begin
                case (cat)
                    0: e_dat++;
                    1: e_sync++;
                    2: e_id++;
                    3: e_hk++;
                    default: e_ext++;
                endcase
            end
            if (frame_start !== (k == 0)) e_fs++;
            if (env_strobe !== env_exp) e_env++;
            if (v.gap && (k % 3 == 0)) begin
                bit_en = 1'b0; prev = dout;
                @(posedge clk); @(negedge clk);
                if (dout !== prev || frame_start !== 1'b0 || env_strobe !== 1'b0) e_gap++;
            end
        end
        check(e_dat == 0, "R1 data bits", e_dat, 0);
        check(e_rdy == 0, "R1 in_ready", e_rdy, 0);
        check(e_fs == 0, "R2 frame_start (R7 length of previous frame)", e_fs, 0);
        check(e_sync == 0, "R3 alignment bits", e_sync, 0);
        check(e_id == 0, "R4 subframe id", e_id, 0);
        check(e_hk == 0, v.load ? "R5 housekeeping" : "R6 staged housekeeping", e_hk, 0);
        check(e_env == 0, "R8 env_strobe", e_env, 0);
        if (v.mode == 2'b10) check(e_ext == 0, "R7 stuffed bit", e_ext, 0);
        if (v.gap) check(e_gap == 0, "R9 idle hold", e_gap, 0);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_P * 100000);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(dout === 1'b0 && frame_start === 1'b0 && env_strobe === 1'b0,
              "R10 outputs in reset", {dout, frame_start, env_strobe}, 0);
        rst_n = 1'b1;
        #1;
        check(in_ready === 1'b1, "R10 in_ready after reset", in_ready, 1);
        @(negedge clk);

        for (int i = 0; i < 5; i++) run_frame(TABLE[i]);

        // R2/R7: the stuffed frame ends exactly; the next bit opens a frame
        bit_en = 1'b1; just_req = 2'b00; din = 1'b1;
        @(posedge clk); @(negedge clk);
        check(frame_start === 1'b1, "R7 frame after stuffed frame", frame_start, 1);
        check(dout === 1'b1, "R1 first data bit", dout, 1);

        // R10: reset in the middle of a frame restarts at the frame's first bit
        repeat (40) begin din = ~din; @(posedge clk); @(negedge clk); end
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check(dout === 1'b0 && frame_start === 1'b0 && env_strobe === 1'b0,
              "R10 outputs cleared", {dout, frame_start, env_strobe}, 0);
        rst_n = 1'b1; din = 1'b1; just_req = 2'b01;
        @(posedge clk); @(negedge clk);
        check(frame_start === 1'b1 && env_strobe === 1'b1, "R10 restart at frame start",
              {frame_start, env_strobe}, 3);
        bit_en = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule